// File: doc/BRIEF.md
# UART Automatic Modem-Line Flow Control

This block is the per-channel modem-line controller of a UART. It drives the active-low request-to-send and data-terminal-ready outputs, and reads the active-low clear-to-send, data-set-ready and ring-indicator inputs. It sits between the serial core and the pins.

On the receive side, each of the two outputs can follow the receive FIFO fill level on its own. A programmable upper threshold and a lower threshold form a hysteresis band. When automatic control of an output is off, the output follows a software level instead.

On the transmit side, the block decides when the core may load the next character. Loss of clear-to-send or data-set-ready halts data only at a character boundary. Pending in-band flow characters are always granted and take priority over data.

A pin remap stage can turn the data-terminal-ready output into either of two signals:
- an RS485 line-driver direction signal that follows the transmitter-empty status;
- a transmit clock output.

It can also take the data-set-ready input as an external receive clock, and the ring-indicator input as an external transmit clock.

The FIFOs, shift registers, baud generator and host registers lie outside the block. They appear only as ports.

Top module: `mfc_modem_ctl`

## Requirements
- R1: With automatic request-to-send enabled, a receive level at or above the upper threshold drives `rts_n` high. The change appears one clock after the level is presented.
- R2: Once `rts_n` is high, it stays high while the level is above the lower threshold. It returns low one clock after the level is at or below the lower threshold. While it is low, levels below the upper threshold keep it low.
- R3: If the lower threshold is not below the upper threshold, the upper threshold is the only switching point. The output is high exactly when the level is at or above the upper threshold, again one clock after the level is presented.
- R4: Automatic data-terminal-ready uses its own enable and the same thresholds. With an automatic enable off, the pin is the inverse of its software level (`sw_rts`, `sw_dtr`; 1 = asserted = pin low).
- R5: With automatic clear-to-send enabled, the transmit hold state is resampled only in cycles where `tx_idle` or `tx_bnd` is 1. A change of `cts_n` while a character is in progress therefore has no effect until the stop boundary. After a boundary sampled with `cts_n` high, `tx_load_data` stays 0 until `cts_n` has been low for three clocks.
- R6: Automatic data-set-ready gates data the same way. When `cfg_rxclk_sel` is 2'b01, the data-set-ready input is not used for gating and `sts_dsr` is 0.
- R7: `tx_load_flow` equals `tx_idle & flow_req` regardless of the hold state. While it is 1, `tx_load_data` is 0. At most one grant is 1 in any cycle.
- R8: With `cfg_dtr_mode` 2'b10, `dtr_n` equals `tx_empty` (the line is driven low while transmitting). With 2'b11, `dtr_n` equals `~tx_empty`. Codes 2'b00 and 2'b01 give the modem function.
- R9: With `cfg_txclk_sel` 2'b01, `dtr_n` carries `tx_clk_1x`. With 2'b10, it carries `tx_clk_nx`. This selection overrides R8 and R4.
- R10: With `cfg_rxclk_sel` 2'b01, `rx_clk_ext` follows `dsr_n`; otherwise it is 0. With `cfg_ri_txclk` 1, `tx_clk_ext` follows `ri_n` and `sts_ri` is 0; otherwise `tx_clk_ext` is 0.
- R11: `cts_n`, `dsr_n` and `ri_n` pass through two flops. The active-high status outputs change two clocks after the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rts_auto | input | 1 | Automatic request-to-send enable |
| cfg_dtr_auto | input | 1 | Automatic data-terminal-ready enable |
| cfg_cts_auto | input | 1 | Clear-to-send transmit gating enable |
| cfg_dsr_auto | input | 1 | Data-set-ready transmit gating enable |
| cfg_thr_hi | input | LVL_W | Upper (stop) threshold |
| cfg_thr_lo | input | LVL_W | Lower (resume) threshold |
| cfg_dtr_mode | input | 2 | RS485 direction mode for dtr_n |
| cfg_txclk_sel | input | 2 | Transmit clock output select on dtr_n |
| cfg_rxclk_sel | input | 2 | 2'b01 takes dsr_n as receive clock |
| cfg_ri_txclk | input | 1 | Takes ri_n as transmit clock |
| sw_rts | input | 1 | Software request-to-send level |
| sw_dtr | input | 1 | Software data-terminal-ready level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_idle | input | 1 | Transmitter ready to load a character |
| tx_bnd | input | 1 | Stop-bit boundary pulse |
| tx_empty | input | 1 | Transmitter-empty status |
| data_req | input | 1 | Data byte waiting |
| flow_req | input | 1 | In-band flow character waiting |
| tx_clk_1x | input | 1 | 1x transmit clock |
| tx_clk_nx | input | 1 | Nx transmit clock |
| cts_n | input | 1 | Clear-to-send pin |
| dsr_n | input | 1 | Data-set-ready pin |
| ri_n | input | 1 | Ring-indicator pin |
| rts_n | output | 1 | Request-to-send pin |
| dtr_n | output | 1 | Data-terminal-ready pin |
| rx_clk_ext | output | 1 | External receive clock |
| tx_clk_ext | output | 1 | External transmit clock |
| sts_cts | output | 1 | Synchronized clear-to-send, active high |
| sts_dsr | output | 1 | Synchronized data-set-ready, active high |
| sts_ri | output | 1 | Synchronized ring indicator, active high |
| tx_load_data | output | 1 | Grant: load a data byte |
| tx_load_flow | output | 1 | Grant: load a flow character |

## Verification
Some properties are checked on every cycle by assertions:
- the set and clear edges of the hysteresis register;
- the freeze of the hold state while a character is in flight;
- the mutual exclusion of the two grants;
- data never being granted while held.

Other behaviour only the bench scenarios can show:
- the full fill-and-drain walk through the band;
- the inverted-threshold fallback;
- a clear-to-send drop and recovery placed in the middle of a character;
- the three-clock resume latency;
- each pin remap mode, as seen at the pins.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    DTRM_MODEM  = 2'b00,
    DTRM_MODEM2 = 2'b01,
    DTRM_485_LO = 2'b10,
    DTRM_485_HI = 2'b11
  } dtr_mode_e;

  typedef enum logic [1:0] {
    TCK_NONE  = 2'b00,
    TCK_1X    = 2'b01,
    TCK_NX    = 2'b10,
    TCK_NONE2 = 2'b11
  } tck_sel_e;

  localparam logic [1:0] RXCK_EXTERNAL = 2'b01;
  localparam int unsigned SYNC_STAGES  = 2;
endpackage

// File: rtl/mfc_sync.sv
module mfc_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/mfc_hyst.sv
module mfc_hyst #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  output logic             stop
);
  logic stop_q, stop_d;
  logic band_ok, at_hi, at_lo;

  always_comb begin
    band_ok = (thr_lo < thr_hi);
    at_hi   = (level >= thr_hi);
    at_lo   = (level <= thr_lo);
    stop_d  = stop_q;
    if (!band_ok)   stop_d = at_hi;
    else if (at_hi) stop_d = 1'b1;
    else if (at_lo) stop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_d;
  end

  assign stop = stop_q;

  p_set_at_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= thr_hi) |=> stop);
  p_clear_at_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_lo < thr_hi && level <= thr_lo) |=> !stop);
  p_hold_in_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_lo < thr_hi && level > thr_lo && level < thr_hi) |=> $stable(stop));
  p_single_point_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_lo >= thr_hi && level < thr_hi) |=> !stop);
endmodule

// File: rtl/mfc_tx_gate.sv
module mfc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_ok,
  input  logic dsr_ok,
  input  logic cts_auto,
  input  logic dsr_auto,
  input  logic tx_idle,
  input  logic tx_bnd,
  input  logic data_req,
  input  logic flow_req,
  output logic load_data,
  output logic load_flow
);
  logic hold_q, hold_d, sample_en;

  always_comb begin
    sample_en = tx_idle | tx_bnd;
    hold_d    = hold_q;
    if (sample_en)
      hold_d = (cts_auto & ~cts_ok) | (dsr_auto & ~dsr_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    load_flow = tx_idle & flow_req;
    load_data = tx_idle & data_req & ~flow_req & ~hold_q;
  end

  p_hold_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_idle || tx_bnd) |=> $stable(hold_q));
  p_grant_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_data, load_flow}));
  p_no_data_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !load_data);
endmodule

// File: rtl/mfc_modem_ctl.sv
module mfc_modem_ctl
  import mfc_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rts_auto,
  input  logic             cfg_dtr_auto,
  input  logic             cfg_cts_auto,
  input  logic             cfg_dsr_auto,
  input  logic [LVL_W-1:0] cfg_thr_hi,
  input  logic [LVL_W-1:0] cfg_thr_lo,
  input  logic [1:0]       cfg_dtr_mode,
  input  logic [1:0]       cfg_txclk_sel,
  input  logic [1:0]       cfg_rxclk_sel,
  input  logic             cfg_ri_txclk,
  input  logic             sw_rts,
  input  logic             sw_dtr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_idle,
  input  logic             tx_bnd,
  input  logic             tx_empty,
  input  logic             data_req,
  input  logic             flow_req,
  input  logic             tx_clk_1x,
  input  logic             tx_clk_nx,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             ri_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             rx_clk_ext,
  output logic             tx_clk_ext,
  output logic             sts_cts,
  output logic             sts_dsr,
  output logic             sts_ri,
  output logic             tx_load_data,
  output logic             tx_load_flow
);
  localparam int unsigned N_IN = 3;

  logic [N_IN-1:0] pins_raw, pins_s;
  logic [1:0]      stop_vec;
  logic            dsr_is_clk, dsr_auto_eff;
  logic            rts_asrt, dtr_asrt;
  dtr_mode_e       dmode;
  tck_sel_e        tsel;

  assign pins_raw = {ri_n, dsr_n, cts_n};

  mfc_sync #(.W(N_IN), .RST_VAL({N_IN{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  // One hysteresis tracker per receive-side output (0: rts, 1: dtr)
  for (genvar g = 0; g < 2; g++) begin : g_hyst
    mfc_hyst #(.LVL_W(LVL_W)) u_hyst (
      .clk(clk), .rst_n(rst_n), .level(rx_level),
      .thr_hi(cfg_thr_hi), .thr_lo(cfg_thr_lo), .stop(stop_vec[g])
    );
  end

  assign dsr_is_clk   = (cfg_rxclk_sel == RXCK_EXTERNAL);
  assign dsr_auto_eff = cfg_dsr_auto & ~dsr_is_clk;

  mfc_tx_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .cts_ok(~pins_s[0]), .dsr_ok(~pins_s[1]),
    .cts_auto(cfg_cts_auto), .dsr_auto(dsr_auto_eff),
    .tx_idle(tx_idle), .tx_bnd(tx_bnd),
    .data_req(data_req), .flow_req(flow_req),
    .load_data(tx_load_data), .load_flow(tx_load_flow)
  );

  always_comb begin
    dmode    = dtr_mode_e'(cfg_dtr_mode);
    tsel     = tck_sel_e'(cfg_txclk_sel);
    rts_asrt = cfg_rts_auto ? ~stop_vec[0] : sw_rts;
    dtr_asrt = cfg_dtr_auto ? ~stop_vec[1] : sw_dtr;
    rts_n    = ~rts_asrt;
    unique case (tsel)
      TCK_1X: dtr_n = tx_clk_1x;
      TCK_NX: dtr_n = tx_clk_nx;
      default: begin
        unique case (dmode)
          DTRM_485_LO: dtr_n = tx_empty;
          DTRM_485_HI: dtr_n = ~tx_empty;
          default:     dtr_n = ~dtr_asrt;
        endcase
      end
    endcase
  end

  assign rx_clk_ext = dsr_is_clk & dsr_n;
  assign tx_clk_ext = cfg_ri_txclk & ri_n;
  assign sts_cts    = ~pins_s[0];
  assign sts_dsr    = ~dsr_is_clk & ~pins_s[1];
  assign sts_ri     = ~cfg_ri_txclk & ~pins_s[2];

  p_sync_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cts_n) |=> ##1 sts_cts);
  p_dsr_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dsr_is_clk |-> !sts_dsr);
endmodule

// File: tb/sim_mfc_modem_ctl.sv
module sim_mfc_modem_ctl;
  localparam int CLK_PER = 10;
  localparam int LW = 8;
  localparam int NV = 11;
  localparam logic [LW-1:0] TV_LVL [NV] = '{8'd0, 8'd8, 8'd12, 8'd13, 8'd8, 8'd5, 8'd4, 8'd8, 8'd11, 8'd12, 8'd3};
  localparam logic          TV_RTS [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0, rst_n;
  logic cfg_rts_auto, cfg_dtr_auto, cfg_cts_auto, cfg_dsr_auto, cfg_ri_txclk;
  logic [LW-1:0] cfg_thr_hi, cfg_thr_lo, rx_level;
  logic [1:0] cfg_dtr_mode, cfg_txclk_sel, cfg_rxclk_sel;
  logic sw_rts, sw_dtr, tx_idle, tx_bnd, tx_empty, data_req, flow_req;
  logic tx_clk_1x, tx_clk_nx, cts_n, dsr_n, ri_n;
  logic rts_n, dtr_n, rx_clk_ext, tx_clk_ext, sts_cts, sts_dsr, sts_ri;
  logic tx_load_data, tx_load_flow;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  mfc_modem_ctl #(.LVL_W(LW)) u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    {cfg_rts_auto, cfg_dtr_auto, cfg_cts_auto, cfg_dsr_auto, cfg_ri_txclk} = '0;
    cfg_thr_hi = 8'd12; cfg_thr_lo = 8'd4; rx_level = '0;
    cfg_dtr_mode = 2'b00; cfg_txclk_sel = 2'b00; cfg_rxclk_sel = 2'b00;
    {sw_rts, sw_dtr, tx_idle, tx_bnd, tx_empty, data_req, flow_req} = '0;
    {tx_clk_1x, tx_clk_nx} = '0;
    cts_n = 0; dsr_n = 0; ri_n = 1;
    step(2);
    // reset state
    chk("R4 reset rts_n", rts_n, 1'b1);
    chk("R4 reset dtr_n", dtr_n, 1'b1);
    chk("R11 reset sts_cts", sts_cts, 1'b0);
    chk("R7 reset grant", tx_load_data | tx_load_flow, 1'b0);
    rst_n = 1;
    step(3);

    // hysteresis walk from the vector table (R1, R2)
    cfg_rts_auto = 1;
    for (int i = 0; i < NV; i++) begin
      rx_level = TV_LVL[i];
      step(1);
      chk($sformatf("R1/R2 vec %0d", i), rts_n, TV_RTS[i]);
    end
    // one-cycle latency check (R1)
    rx_level = 8'd20; #1;
    chk("R1 not before clock", rts_n, 1'b0);
    step(1);
    chk("R1 one clock later", rts_n, 1'b1);
    rx_level = 8'd0; step(1);

    // inverted thresholds (R3)
    cfg_thr_hi = 8'd6; cfg_thr_lo = 8'd9;
    rx_level = 8'd5; step(1); chk("R3 below hi", rts_n, 1'b0);
    rx_level = 8'd6; step(1); chk("R3 at hi", rts_n, 1'b1);
    rx_level = 8'd5; step(1); chk("R3 back below hi", rts_n, 1'b0);
    cfg_thr_hi = 8'd12; cfg_thr_lo = 8'd4;

    // DTR automatic and software (R4)
    cfg_rts_auto = 0; sw_rts = 1; cfg_dtr_auto = 1; sw_dtr = 1;
    rx_level = 8'd12; step(1);
    chk("R4 sw rts asserted", rts_n, 1'b0);
    chk("R4 dtr auto stop", dtr_n, 1'b1);
    rx_level = 8'd4; step(1);
    chk("R4 dtr auto resume", dtr_n, 1'b0);
    cfg_dtr_auto = 0; sw_dtr = 0; #1;
    chk("R4 sw dtr deasserted", dtr_n, 1'b1);

    // synchronizer latency (R11)
    cts_n = 1; step(1);
    chk("R11 after one clock", sts_cts, 1'b1);
    step(1);
    chk("R11 after two clocks", sts_cts, 1'b0);
    cts_n = 0; step(3);

    // CTS gating at character boundary (R5)
    cfg_cts_auto = 1; tx_idle = 1; data_req = 1; step(1);
    chk("R5 data granted idle", tx_load_data, 1'b1);
    tx_idle = 0; cts_n = 1; step(4);       // mid-character drop
    tx_idle = 1; cts_n = 0; #1;
    chk("R5 mid-char drop ignored", tx_load_data, 1'b1);
    step(3);
    tx_idle = 0; step(1);
    cts_n = 1; step(3);                     // drop, still mid-character
    tx_bnd = 1; step(1); tx_bnd = 0; tx_idle = 1; #1;
    chk("R5 held after boundary", tx_load_data, 1'b0);
    flow_req = 1; #1;
    chk("R7 flow while held", tx_load_flow, 1'b1);
    flow_req = 0;
    cts_n = 0; step(2);
    chk("R5 still held 2 clocks", tx_load_data, 1'b0);
    step(1);
    chk("R5 resume 3 clocks", tx_load_data, 1'b1);

    // priority (R7)
    flow_req = 1; #1;
    chk("R7 flow first", tx_load_flow, 1'b1);
    chk("R7 data blocked", tx_load_data, 1'b0);
    flow_req = 0; cfg_cts_auto = 0;

    // DSR gating and remap (R6, R10)
    cfg_dsr_auto = 1; dsr_n = 1; step(3);
    chk("R6 dsr held", tx_load_data, 1'b0);
    cfg_rxclk_sel = 2'b01; step(1);
    chk("R6 dsr as clock ignored", tx_load_data, 1'b1);
    chk("R6 sts_dsr masked", sts_dsr, 1'b0);
    chk("R10 rx clk high", rx_clk_ext, 1'b1);
    dsr_n = 0; #1;
    chk("R10 rx clk low", rx_clk_ext, 1'b0);
    cfg_rxclk_sel = 2'b00; #1;
    dsr_n = 1; #1;
    chk("R10 rx clk off", rx_clk_ext, 1'b0);
    cfg_dsr_auto = 0; dsr_n = 0;
    cfg_ri_txclk = 1; ri_n = 0; #1;
    chk("R10 tx clk low", tx_clk_ext, 1'b0);
    ri_n = 1; #1;
    chk("R10 tx clk high", tx_clk_ext, 1'b1);
    ri_n = 0; step(3);
    chk("R10 sts_ri masked", sts_ri, 1'b0);
    cfg_ri_txclk = 0; #1;
    chk("R10 sts_ri live", sts_ri, 1'b1);
    chk("R10 tx clk off", tx_clk_ext, 1'b0);

    // RS485 direction (R8)
    sw_dtr = 1; cfg_dtr_mode = 2'b10; tx_empty = 0; #1;
    chk("R8 lo sending", dtr_n, 1'b0);
    tx_empty = 1; #1;
    chk("R8 lo empty", dtr_n, 1'b1);
    cfg_dtr_mode = 2'b11; #1;
    chk("R8 hi empty", dtr_n, 1'b0);
    tx_empty = 0; #1;
    chk("R8 hi sending", dtr_n, 1'b1);

    // clock output on dtr_n (R9)
    cfg_txclk_sel = 2'b01; tx_clk_1x = 0; tx_clk_nx = 1; #1;
    chk("R9 1x low", dtr_n, 1'b0);
    tx_clk_1x = 1; tx_clk_nx = 0; #1;
    chk("R9 1x high", dtr_n, 1'b1);
    cfg_txclk_sel = 2'b10; #1;
    chk("R9 nx low", dtr_n, 1'b0);
    tx_clk_nx = 1; tx_clk_1x = 0; #1;
    chk("R9 nx high", dtr_n, 1'b1);
    cfg_txclk_sel = 2'b00; cfg_dtr_mode = 2'b00; #1;
    chk("R9 back to modem", dtr_n, 1'b0);

    step(2);
    finish_run();
  end
endmodule